// File: doc/BRIEF.md
# Sized Integer ALU with Status Flags

This block adds, subtracts, ANDs, ORs or XORs two 32-bit operands at a width picked by a size input: 8, 16 or 32 bits. Narrow operations use only the low part of each operand. The result is combinational. It is masked to the chosen width, and the bits above that width read as zero.

Six status flags are derived at the same width: carry/borrow, overflow, sign, zero, nibble carry and low-byte parity. They are captured into a flags register on a clock edge where the flag write enable is high. The register also keeps a direction bit. Only a separate load strobe can change that bit, and ALU operations never touch it.

A sequencer drives the operands and the operation, reads the result at once, and raises the write enable when the instruction should update the flags.

Top module: `alu_flags`

## Requirements
- R1: With op 0 (add), result equals the sum of the low `n` bits of `opa` and `opb`, truncated to `n` bits. `n` is 8 for size 0, 16 for size 1, and 32 for size 2 or 3. Result bits at position `n` and above are zero.
- R2: With op 1 (subtract), result equals low `n` bits of `opa` minus low `n` bits of `opb`, truncated to `n` bits and zero above.
- R3: Op 2 gives AND, op 3 gives OR, and ops 4 to 7 give XOR, all at width `n`. A logic operation writes carry, overflow and nibble carry as 0.
- R4: flags[0] (carry) is set when an add carries out of bit `n-1`, or when a subtract borrows because the unsigned `opa` is below the unsigned `opb`.
- R5: flags[5] (overflow) is set when the signed result at width `n` does not fit: for an add, both operands have the same sign and the result sign differs; for a subtract, the operand signs differ and the result sign differs from `opa`.
- R6: flags[4] (sign) takes result bit `n-1`. flags[3] (zero) is set when the `n`-bit result is all zeros.
- R7: flags[2] (nibble carry) is set when an add or subtract carries or borrows between bit 3 and bit 4.
- R8: flags[1] (parity) is set when result bits 7:0 hold an even number of ones.
- R9: flags[5:0] load on a rising clock edge with `flags_we` high, hold otherwise, and reset to zero when `rst_n` is low.
- R10: flags[6] (direction) loads `dir_in` on an edge with `dir_load` high, holds otherwise, ignores `flags_we`, and resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op | input | 3 | 0 add, 1 subtract, 2 AND, 3 OR, 4-7 XOR |
| size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| flags_we | input | 1 | Capture the six status flags |
| dir_load | input | 1 | Load the direction bit |
| dir_in | input | 1 | New direction bit value |
| result | output | 32 | Operation result, zero above the chosen width |
| flags | output | 7 | {dir, overflow, sign, zero, nibble carry, parity, carry} |

## Verification
Several properties are checked on every cycle. The status flags hold when the write enable is low. The direction bit follows its own strobe and nothing else. Logic operations leave carry, overflow and nibble carry cleared. The captured parity and zero flags agree with the result seen one cycle earlier. Masking of the upper result bits for byte and halfword sizes is also checked every cycle. The arithmetic itself can only be shown by the bench's directed vectors: the values of carry versus borrow, signed overflow at each width, and the nibble carry. These vectors sit on the wrap points of each size.

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [2:0]  op,
  input  logic [1:0]  size,
  input  logic        flags_we,
  input  logic        dir_load,
  input  logic        dir_in,
  output logic [31:0] result,
  output logic [6:0]  flags
);
  logic [31:0] mask, am, bm, raw;
  logic [32:0] sum, dif;
  logic        msb_a, msb_b, msb_r, carry_out, is_arith, is_sub;
  logic [5:0]  nxt;
  logic [5:0]  stat_q;
  logic        dir_q;

  assign mask = (size == 2'd0) ? 32'h0000_00FF :
                (size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign am = opa & mask;
  assign bm = opb & mask;
  assign sum = {1'b0, am} + {1'b0, bm};
  assign dif = {1'b0, am} - {1'b0, bm};
  assign is_sub = (op == 3'd1);
  assign is_arith = (op == 3'd0) || is_sub;

  always_comb begin
    case (op)
      3'd0:    raw = sum[31:0];
      3'd1:    raw = dif[31:0];
      3'd2:    raw = am & bm;
      3'd3:    raw = am | bm;
      default: raw = am ^ bm;
    endcase
  end

  assign result = raw & mask;

  always_comb begin
    case (size)
      2'd0:    begin msb_a = am[7];  msb_b = bm[7];  msb_r = result[7];  carry_out = sum[8];  end
      2'd1:    begin msb_a = am[15]; msb_b = bm[15]; msb_r = result[15]; carry_out = sum[16]; end
      default: begin msb_a = am[31]; msb_b = bm[31]; msb_r = result[31]; carry_out = sum[32]; end
    endcase
  end

  assign nxt[0] = is_arith & (is_sub ? (am < bm) : carry_out);
  assign nxt[1] = ~^result[7:0];
  assign nxt[2] = is_arith & (am[4] ^ bm[4] ^ result[4]);
  assign nxt[3] = (result == 32'd0);
  assign nxt[4] = msb_r;
  assign nxt[5] = is_arith & (msb_r != msb_a) & (is_sub ? (msb_a != msb_b) : (msb_a == msb_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (flags_we) stat_q <= nxt;
      if (dir_load) dir_q <= dir_in;
    end
  end

  assign flags = {dir_q, stat_q};
endmodule

module alu_flags_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  op,
  input logic [1:0]  size,
  input logic        flags_we,
  input logic        dir_load,
  input logic        dir_in,
  input logic [31:0] result,
  input logic [6:0]  flags
);
  assert_byte_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd0) |-> (result[31:8] == 24'd0));
  assert_half_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'd1) |-> (result[31:16] == 16'd0));
  assert_logic_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && op >= 3'd2) |=> (flags[0] == 1'b0 && flags[2] == 1'b0 && flags[5] == 1'b0));
  assert_zero_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> (flags[3] == ($past(result) == 32'd0)));
  assert_parity_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> (flags[1] == ~^$past(result[7:0])));
  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we |=> $stable(flags[5:0]));
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_load |=> $stable(flags[6]));
  assert_dir_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dir_load |=> (flags[6] == $past(dir_in)));
endmodule

bind alu_flags alu_flags_checker u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .size(size), .flags_we(flags_we),
  .dir_load(dir_load), .dir_in(dir_in), .result(result), .flags(flags)
);

// File: tb/alu_flags_test.sv
module alu_flags_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic        flags_we = 1'b0, dir_load = 1'b0, dir_in = 1'b0;
  logic [31:0] result;
  logic [6:0]  flags;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  alu_flags uut (
    .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op(op), .size(size),
    .flags_we(flags_we), .dir_load(dir_load), .dir_in(dir_in),
    .result(result), .flags(flags)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [2:0] o, input logic [1:0] s,
                        input logic [31:0] a, input logic [31:0] b, input logic we,
                        input logic [31:0] exp_r, input logic [6:0] exp_f);
    @(negedge clk);
    op = o; size = s; opa = a; opb = b; flags_we = we;
    #1 check({req, " result"}, result, exp_r);
    @(negedge clk);
    flags_we = 1'b0;
    check({req, " flags"}, {25'd0, flags}, {25'd0, exp_f});
  endtask

  task automatic t_reset;
    check("R9 reset flags", {25'd0, flags}, 32'd0);
    check("R10 reset dir", {31'd0, flags[6]}, 32'd0);
  endtask

  task automatic t_add;
    run_op("R1 R4 R7 R8 byte wrap", 3'd0, 2'd0, 32'h1234_56FF, 32'hABCD_EF01, 1'b1, 32'h0, 7'h0F);
    run_op("R5 R6 byte overflow", 3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b1, 32'h80, 7'h34);
    run_op("R5 half overflow", 3'd0, 2'd1, 32'hFFFF_7FFF, 32'h0000_0001, 1'b1, 32'h8000, 7'h36);
    run_op("R4 word carry", 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 32'h1, 7'h05);
    run_op("R1 size3 as word", 3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0, 7'h2B);
  endtask

  task automatic t_sub;
    run_op("R2 R4 byte borrow", 3'd1, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b1, 32'hFF, 7'h17);
    run_op("R2 R5 R7 byte overflow", 3'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b1, 32'h7F, 7'h24);
    run_op("R2 R6 word zero", 3'd1, 2'd2, 32'h1234_5678, 32'h1234_5678, 1'b1, 32'h0, 7'h0A);
  endtask

  task automatic t_logic;
    run_op("R4 set carry first", 3'd0, 2'd0, 32'h0000_00F8, 32'h0000_0018, 1'b1, 32'h10, 7'h05);
    run_op("R3 and half", 3'd2, 2'd1, 32'hFFFF_F0F0, 32'h0000_FF0F, 1'b1, 32'hF000, 7'h12);
    run_op("R3 or byte", 3'd3, 2'd0, 32'hFFFF_FF00, 32'h0000_0000, 1'b1, 32'h0, 7'h0A);
    run_op("R3 xor word", 3'd4, 2'd2, 32'h8000_0000, 32'h0000_0003, 1'b1, 32'h8000_0003, 7'h12);
    run_op("R3 xor code 7", 3'd7, 2'd0, 32'h0000_000F, 32'h0000_0001, 1'b1, 32'h0E, 7'h00);
  endtask

  task automatic t_hold;
    run_op("R9 hold without enable", 3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0, 7'h00);
  endtask

  task automatic t_dir;
    @(negedge clk);
    dir_load = 1'b1; dir_in = 1'b1;
    @(negedge clk);
    dir_load = 1'b0; dir_in = 1'b0;
    check("R10 dir loaded", {31'd0, flags[6]}, 32'd1);
    run_op("R10 dir kept by flag write", 3'd1, 2'd2, 32'h5, 32'h5, 1'b1, 32'h0, 7'h4A);
    @(negedge clk);
    dir_load = 1'b1; dir_in = 1'b0;
    @(negedge clk);
    dir_load = 1'b0;
    check("R10 dir cleared, status kept", {25'd0, flags}, 32'h0A);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_hold();
    t_dir();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule